// File: doc/BRIEF.md
# Packed Integer Lane Arithmetic Unit

This block is a single-cycle packed integer execution unit for a 64-bit datapath. Each request carries two 64-bit operands, a four-bit operation code and a two-bit lane-size select. The operands are split into eight bytes, four halfwords, two words or one doubleword, and the operation is applied to each lane on its own. Bit 0 of every lane is the lane's least significant bit, and lane 0 occupies the lowest bits of the operand.

The unit provides the following operations:

- Add and subtract with wraparound.
- Add and subtract with signed or unsigned saturation.
- Rounding average.
- Per-lane equality and signed greater-than masks.
- Minimum and maximum.
- Five bitwise operations on the whole 64-bit word.

A request is presented with `validIn` high for one cycle. One cycle later the registered result appears together with a one-cycle `validOut` strobe. There is no back-pressure. Some combinations of operation and lane size have no defined meaning. For these the unit returns zero and raises `illegalOut` for that one result. Between requests, the result register keeps its last value.

Top module: `lane_alu`

## Requirements
- R1: While `rstN` is low, `validOut` and `illegalOut` are 0 and `result` is all zeros.
- R2: Wraparound add (opCode 0) and wraparound subtract, A minus B (opCode 1), work for every lane size. laneSel encodes the size: 0 is byte, 1 is halfword, 2 is word, 3 is doubleword. No carry or borrow crosses a lane boundary.
- R3: Signed-saturating add (opCode 2) and subtract (opCode 3), for byte and halfword lanes only, clamp an overflowing lane to the signed limit: 0x7F/0x80 for bytes and 0x7FFF/0x8000 for halfwords.
- R4: Unsigned-saturating add (opCode 4) clamps to all ones, and unsigned-saturating subtract (opCode 5) clamps to zero. Both apply to byte and halfword lanes only.
- R5: Average (opCode 6), for byte and halfword lanes, gives (A + B + 1) >> 1 per lane. The operands are unsigned and the carry out of the sum is kept.
- R6: Equality (opCode 7) and signed greater-than A > B (opCode 8), for byte, halfword and word lanes, write all ones into a lane where the condition holds and all zeros where it does not.
- R7: Minimum (opCode 9) and maximum (opCode 10) compare unsigned for byte lanes and signed for halfword lanes. No other lane size is legal for them.
- R8: The bitwise operations act on all 64 bits whatever laneSel holds: AND (11), OR (12), XOR (13), NOR (14) and AND-NOT (15). AND-NOT computes (not A) and B. NOR of an operand with itself yields its complement.
- R9: An operation code used with a lane size it does not support returns a zero result with `validOut` and `illegalOut` both high for exactly that one cycle.
- R10: `validOut` rises in the cycle after `validIn`. While `validIn` is low, `result` holds its value and `validOut` stays low. Back-to-back requests produce back-to-back results in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Request strobe |
| opCode | input | 4 | Operation code |
| laneSel | input | 2 | Lane size: 0 byte, 1 halfword, 2 word, 3 doubleword |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand |
| validOut | output | 1 | Result strobe, one cycle |
| result | output | 64 | Registered result |
| illegalOut | output | 1 | Unsupported combination flag, one cycle |

## Verification
The hardest case to reach is a lane that overflows while its neighbour does not. A fault in the saturation or carry isolation only shows up when two adjacent lanes take opposite clamp directions, or when one lane clamps and the next stays in range. The stimulus therefore uses hand-built operand words in which each lane is set to a different edge value:

- the signed limits;
- 0xFF plus 1;
- 0 minus 1;
- values that differ only in the sign bit.

These words are issued back to back, and also at every illegal lane size, so that ordering and the clearing of the error flag are exercised at the same time.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;

  localparam int WORD_W   = 64;
  localparam int OP_W     = 4;
  localparam int SIZE_W   = 2;
  localparam int NUM_SIZE = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_ADDSS = 4'd2,
    OP_SUBSS = 4'd3,
    OP_ADDUS = 4'd4,
    OP_SUBUS = 4'd5,
    OP_AVG   = 4'd6,
    OP_EQ    = 4'd7,
    OP_GT    = 4'd8,
    OP_MIN   = 4'd9,
    OP_MAX   = 4'd10,
    OP_AND   = 4'd11,
    OP_OR    = 4'd12,
    OP_XOR   = 4'd13,
    OP_NOR   = 4'd14,
    OP_ANDN  = 4'd15
  } opKind_t;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } laneSize_t;

  typedef struct packed {
    logic load;      // capture a new result this cycle
    logic illegal;   // the captured result must be forced to zero
    logic bitwise;   // take the full-width logic path
  } ctrlStrobes_t;

endpackage

// File: rtl/lane_alu_slice.sv
module lane_alu_slice
  import lane_alu_pkg::*;
#(
  parameter int W            = 8,
  parameter bit SignedMinMax = 1'b0
) (
  input  opKind_t        opCode,
  input  logic [W-1:0]   laneA,
  input  logic [W-1:0]   laneB,
  output logic [W-1:0]   laneY
);

  localparam logic [W-1:0] SAT_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SAT_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONE = {W{1'b1}};

  logic [W:0]   sumU;
  logic [W:0]   difU;
  logic [W:0]   sumS;
  logic [W:0]   difS;
  logic [W-1:0] avgVal;
  logic         gtSigned;
  logic         aBelow;

  assign sumU = {1'b0, laneA} + {1'b0, laneB};
  assign difU = {1'b0, laneA} - {1'b0, laneB};
  assign sumS = {laneA[W-1], laneA} + {laneB[W-1], laneB};
  assign difS = {laneA[W-1], laneA} - {laneB[W-1], laneB};

  // floor((a+b+1)/2) without a wider adder: halves plus the rounding bit
  assign avgVal = (laneA >> 1) + (laneB >> 1) + {{(W-1){1'b0}}, laneA[0] | laneB[0]};

  assign gtSigned = $signed(laneA) > $signed(laneB);

  generate
    if (SignedMinMax) begin : g_sMinMax
      assign aBelow = $signed(laneA) < $signed(laneB);
    end else begin : g_uMinMax
      assign aBelow = laneA < laneB;
    end
  endgenerate

  always_comb begin
    laneY = '0;
    unique case (opCode)
      OP_ADD:   laneY = sumU[W-1:0];
      OP_SUB:   laneY = difU[W-1:0];
      OP_ADDSS: laneY = (sumS[W] != sumS[W-1]) ? (sumS[W] ? SAT_NEG : SAT_POS) : sumS[W-1:0];
      OP_SUBSS: laneY = (difS[W] != difS[W-1]) ? (difS[W] ? SAT_NEG : SAT_POS) : difS[W-1:0];
      OP_ADDUS: laneY = sumU[W] ? ALL_ONE : sumU[W-1:0];
      OP_SUBUS: laneY = difU[W] ? '0 : difU[W-1:0];
      OP_AVG:   laneY = avgVal;
      OP_EQ:    laneY = (laneA == laneB) ? ALL_ONE : '0;
      OP_GT:    laneY = gtSigned ? ALL_ONE : '0;
      OP_MIN:   laneY = aBelow ? laneA : laneB;
      OP_MAX:   laneY = aBelow ? laneB : laneA;
      default:  laneY = '0;
    endcase
  end

endmodule

// File: rtl/lane_alu_ctrl.sv
module lane_alu_ctrl
  import lane_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  opKind_t      opCode,
  input  laneSize_t    laneSel,
  output ctrlStrobes_t strobes,
  output logic         validOut,
  output logic         illegalOut
);

  logic narrowOk;   // byte or halfword
  logic cmpOk;      // byte, halfword or word
  logic comboOk;

  assign narrowOk = (laneSel == SZ_BYTE) || (laneSel == SZ_HALF);
  assign cmpOk    = (laneSel != SZ_DBL);

  always_comb begin
    unique case (opCode)
      OP_ADD, OP_SUB:                        comboOk = 1'b1;
      OP_ADDSS, OP_SUBSS, OP_ADDUS, OP_SUBUS: comboOk = narrowOk;
      OP_AVG, OP_MIN, OP_MAX:                comboOk = narrowOk;
      OP_EQ, OP_GT:                          comboOk = cmpOk;
      default:                               comboOk = 1'b1;
    endcase
  end

  assign strobes.load    = validIn;
  assign strobes.illegal = !comboOk;
  assign strobes.bitwise = (opCode == OP_AND) || (opCode == OP_OR) || (opCode == OP_XOR) ||
                           (opCode == OP_NOR) || (opCode == OP_ANDN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut   <= 1'b0;
      illegalOut <= 1'b0;
    end else begin
      validOut   <= validIn;
      illegalOut <= validIn && !comboOk;
    end
  end

endmodule

// File: rtl/lane_alu_dp.sv
module lane_alu_dp
  import lane_alu_pkg::*;
#(
  parameter int DataW = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  opKind_t           opCode,
  input  laneSize_t         laneSel,
  input  logic [DataW-1:0]  srcA,
  input  logic [DataW-1:0]  srcB,
  output logic [DataW-1:0]  result
);

  logic [NUM_SIZE-1:0][DataW-1:0] sizeRes;
  logic [DataW-1:0]               bitRes;
  logic [DataW-1:0]               nextRes;

  genvar s, l;
  generate
    for (s = 0; s < NUM_SIZE; s++) begin : g_size
      localparam int LW = 8 << s;
      localparam int LN = DataW / LW;
      for (l = 0; l < LN; l++) begin : g_lane
        lane_alu_slice #(
          .W            (LW),
          .SignedMinMax (LW == 16)
        ) u_slice (
          .opCode (opCode),
          .laneA  (srcA[l*LW +: LW]),
          .laneB  (srcB[l*LW +: LW]),
          .laneY  (sizeRes[s][l*LW +: LW])
        );
      end
    end
  endgenerate

  always_comb begin
    unique case (opCode)
      OP_AND:  bitRes = srcA & srcB;
      OP_OR:   bitRes = srcA | srcB;
      OP_XOR:  bitRes = srcA ^ srcB;
      OP_NOR:  bitRes = ~(srcA | srcB);
      OP_ANDN: bitRes = ~srcA & srcB;
      default: bitRes = '0;
    endcase
  end

  always_comb begin
    if (strobes.illegal)      nextRes = '0;
    else if (strobes.bitwise) nextRes = bitRes;
    else                      nextRes = sizeRes[laneSel];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             result <= '0;
    else if (strobes.load) result <= nextRes;
  end

endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         validIn,
  input  logic [3:0]   opCode,
  input  logic [1:0]   laneSel,
  input  logic [63:0]  srcA,
  input  logic [63:0]  srcB,
  output logic         validOut,
  output logic [63:0]  result,
  output logic         illegalOut
);

  ctrlStrobes_t strobes;
  opKind_t      opKind;
  laneSize_t    laneKind;

  assign opKind   = opKind_t'(opCode);
  assign laneKind = laneSize_t'(laneSel);

  lane_alu_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .validIn    (validIn),
    .opCode     (opKind),
    .laneSel    (laneKind),
    .strobes    (strobes),
    .validOut   (validOut),
    .illegalOut (illegalOut)
  );

  lane_alu_dp #(.DataW(WORD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .opCode  (opKind),
    .laneSel (laneKind),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result)
  );

endmodule

// File: rtl/lane_alu_chk.sv
module lane_alu_chk (
  input logic         clk,
  input logic         rstN,
  input logic         validIn,
  input logic [3:0]   opCode,
  input logic [1:0]   laneSel,
  input logic [63:0]  srcA,
  input logic [63:0]  srcB,
  input logic         validOut,
  input logic [63:0]  result,
  input logic         illegalOut
);

  function automatic logic halvesAreMasks(logic [63:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      ok = ok && ((v[i*16 +: 16] == 16'h0000) || (v[i*16 +: 16] == 16'hFFFF));
    end
    return ok;
  endfunction

  a_r1_reset_clears: assert property (@(posedge clk)
    !rstN |=> (!validOut && !illegalOut && result == 64'd0));

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!validOut && $stable(result)));

  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> (validOut && result == 64'd0));

  a_r8_andn_full: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opCode == 4'd15) |=> (result == (~$past(srcA) & $past(srcB))));

  a_r6_half_eq_mask: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && opCode == 4'd7 && laneSel == 2'd1) |=> halvesAreMasks(result));

endmodule

bind lane_alu lane_alu_chk u_chk (.*);

// File: tb/lane_alu_bench.sv
module lane_alu_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [3:0]  opCode = '0;
  logic [1:0]  laneSel = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        validOut;
  logic [63:0] result;
  logic        illegalOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        ill;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [63:0] lastRes = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_alu u_lane_alu (
    .clk(clk), .rstN(rstN), .validIn(validIn), .opCode(opCode), .laneSel(laneSel),
    .srcA(srcA), .srcB(srcB), .validOut(validOut), .result(result), .illegalOut(illegalOut)
  );

  function automatic logic [64:0] refCalc(logic [3:0] op, logic [1:0] ls,
                                          logic [63:0] a, logic [63:0] b);
    logic        bad;
    logic [63:0] res;
    int          w, n;
    bad = 1'b0;
    case (op)
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd9, 4'd10: bad = (ls > 2'd1);
      4'd7, 4'd8: bad = (ls == 2'd3);
      default: bad = 1'b0;
    endcase
    res = '0;
    if (bad) return {1'b1, 64'd0};
    case (op)
      4'd11: return {1'b0, a & b};
      4'd12: return {1'b0, a | b};
      4'd13: return {1'b0, a ^ b};
      4'd14: return {1'b0, ~(a | b)};
      4'd15: return {1'b0, ~a & b};
      default: ;
    endcase
    w = 8 << ls;
    n = 64 / w;
    for (int i = 0; i < n; i++) begin
      logic [65:0]        av, bv, r, msk;
      logic signed [65:0] sa, sb, sr, smax, smin;
      msk = (66'd1 << w) - 66'd1;
      av  = ({2'b00, a} >> (i*w)) & msk;
      bv  = ({2'b00, b} >> (i*w)) & msk;
      sa  = $signed(av);
      sb  = $signed(bv);
      if (av[w-1]) sa = sa - $signed(66'd1 << w);
      if (bv[w-1]) sb = sb - $signed(66'd1 << w);
      smax = $signed((66'd1 << (w-1)) - 66'd1);
      smin = -$signed(66'd1 << (w-1));
      r = '0;
      case (op)
        4'd0: r = av + bv;
        4'd1: r = av - bv;
        4'd2, 4'd3: begin
          sr = (op == 4'd2) ? (sa + sb) : (sa - sb);
          if (sr > smax) sr = smax;
          if (sr < smin) sr = smin;
          r = sr;
        end
        4'd4: begin r = av + bv; if (r > msk) r = msk; end
        4'd5: r = (av < bv) ? 66'd0 : (av - bv);
        4'd6: r = (av + bv + 66'd1) >> 1;
        4'd7: r = (av == bv) ? msk : 66'd0;
        4'd8: r = (sa > sb) ? msk : 66'd0;
        4'd9:  r = (ls == 2'd0) ? ((av < bv) ? av : bv) : ((sa < sb) ? av : bv);
        4'd10: r = (ls == 2'd0) ? ((av < bv) ? bv : av) : ((sa < sb) ? bv : av);
        default: r = '0;
      endcase
      res = res | ((r[63:0] & msk[63:0]) << (i*w));
    end
    return {1'b0, res};
  endfunction

  task automatic drive(input logic [3:0] op, input logic [1:0] ls,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    expItem_t    it;
    logic [64:0] e;
    @(negedge clk);
    validIn = 1'b1; opCode = op; laneSel = ls; srcA = a; srcB = b;
    e = refCalc(op, ls, a, b);
    it.res = e[63:0]; it.ill = e[64]; it.tag = tag;
    expQ.push_back(it);
    lastRes = e[63:0];
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      validIn = 1'b0;
      srcA = ~srcA; srcB = srcB + 64'd3; opCode = opCode + 4'd1;
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a result strobe is seen
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (validOut) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R10 unexpected result", result, 64'd0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(result == it.res, it.tag, result, it.res);
          check(illegalOut == it.ill, {it.tag, " R9 flag"}, {63'd0, illegalOut}, {63'd0, it.ill});
        end
      end else begin
        check(!illegalOut, "R9 flag without result", {63'd0, illegalOut}, 64'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!validOut && !illegalOut && result == 64'd0, "R1 reset state", result, 64'd0);
    rstN = 1'b1;
    idle(2);

    // R2 wraparound at every size, carries must stay inside lanes
    drive(4'd0, 2'd0, 64'hFF01_7F80_00FF_1234, 64'h0101_0180_0101_4321, "R2 add byte");
    drive(4'd0, 2'd1, 64'hFFFF_8000_0001_7FFF, 64'h0001_8000_FFFF_0001, "R2 add half");
    drive(4'd0, 2'd2, 64'hFFFF_FFFF_1234_5678, 64'h0000_0001_1111_1111, "R2 add word");
    drive(4'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002, "R2 add dword");
    drive(4'd1, 2'd0, 64'h0001_0203_0405_0607, 64'h0102_0304_0000_0808, "R2 sub byte");
    drive(4'd1, 2'd3, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, "R2 sub dword");
    drive(4'd1, 2'd2, 64'h0000_0000_8000_0000, 64'h0000_0001_0000_0001, "R2 sub word");

    // R3 signed saturation, neighbours clamp opposite ways
    drive(4'd2, 2'd0, 64'h7F80_7F80_0102_40C0, 64'h0180_80FF_FEFE_40C0, "R3 ss add byte");
    drive(4'd3, 2'd0, 64'h807F_0010_7F80_0000, 64'h0180_2000_FF01_8000, "R3 ss sub byte");
    drive(4'd2, 2'd1, 64'h7FFF_8000_4000_C000, 64'h0001_FFFF_4000_C000, "R3 ss add half");
    drive(4'd3, 2'd1, 64'h8000_7FFF_0005_FFFF, 64'h0001_FFFF_0007_7FFF, "R3 ss sub half");

    // R4 unsigned saturation
    drive(4'd4, 2'd0, 64'hFF80_0102_FE7F_0000, 64'h0180_FEFE_0101_0000, "R4 us add byte");
    drive(4'd5, 2'd0, 64'h0010_FF00_0102_8080, 64'h0100_FE01_0203_7F81, "R4 us sub byte");
    drive(4'd4, 2'd1, 64'hFFFF_8000_1234_0001, 64'h0001_8000_1111_FFFE, "R4 us add half");
    drive(4'd5, 2'd1, 64'h0000_8000_1234_FFFF, 64'h0001_7FFF_1235_0000, "R4 us sub half");

    // R5 rounding average, carry kept
    drive(4'd6, 2'd0, 64'hFFFF_0001_0203_FE80, 64'hFFFE_0000_0102_FF81, "R5 avg byte");
    drive(4'd6, 2'd1, 64'hFFFF_0001_8000_1234, 64'hFFFF_0000_8001_4321, "R5 avg half");

    // R6 compare masks, signed greater-than
    drive(4'd7, 2'd0, 64'h0011_2233_4455_6677, 64'h0011_2234_4455_6676, "R6 eq byte");
    drive(4'd8, 2'd0, 64'h7F80_0001_FF00_0101, 64'h807F_00FF_00FF_0100, "R6 gt byte");
    drive(4'd8, 2'd1, 64'h7FFF_8000_0001_FFFF, 64'h8000_7FFF_0001_0000, "R6 gt half");
    drive(4'd7, 2'd2, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0002, "R6 eq word");
    drive(4'd8, 2'd2, 64'h8000_0000_7FFF_FFFF, 64'h7FFF_FFFF_8000_0000, "R6 gt word");

    // R7 min/max signedness by lane size
    drive(4'd9,  2'd0, 64'h80FF_0102_7F00_AA55, 64'h7F01_0201_8001_55AA, "R7 min byte unsigned");
    drive(4'd10, 2'd0, 64'h80FF_0102_7F00_AA55, 64'h7F01_0201_8001_55AA, "R7 max byte unsigned");
    drive(4'd9,  2'd1, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF, "R7 min half signed");
    drive(4'd10, 2'd1, 64'h8000_7FFF_FFFF_0001, 64'h7FFF_8000_0001_FFFF, "R7 max half signed");

    // R8 bitwise over full width, lane size irrelevant
    drive(4'd11, 2'd3, 64'hF0F0_1234_5678_9ABC, 64'hFF00_FFFF_0000_0F0F, "R8 and");
    drive(4'd12, 2'd0, 64'hF0F0_1234_5678_9ABC, 64'h0F0F_0000_0001_0000, "R8 or");
    drive(4'd13, 2'd1, 64'hAAAA_5555_FFFF_0000, 64'h5555_5555_0F0F_1234, "R8 xor");
    drive(4'd14, 2'd2, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, "R8 nor self is not");
    drive(4'd15, 2'd3, 64'hFF00_F0F0_0000_FFFF, 64'h0FF0_FFFF_1234_FFFF, "R8 andn");

    // R9 illegal combos back to back with legal ones
    drive(4'd2,  2'd2, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, "R9 ss add word");
    drive(4'd0,  2'd0, 64'h0101_0101_0101_0101, 64'h0101_0101_0101_0101, "R9 legal after illegal");
    drive(4'd7,  2'd3, 64'h5, 64'h5, "R9 eq dword");
    drive(4'd10, 2'd2, 64'h5, 64'h6, "R9 max word");
    drive(4'd6,  2'd3, 64'h5, 64'h6, "R9 avg dword");
    drive(4'd5,  2'd2, 64'h5, 64'h6, "R9 us sub word");
    drive(4'd0,  2'd3, 64'h1234, 64'h1, "R10 last of burst");
    idle(1);

    // R10: result holds while idle, no strobe
    idle(4);
    check(!validOut && result == lastRes, "R10 hold while idle", result, lastRes);
    check(expQ.size() == 0, "R10 all results returned", 64'(expQ.size()), 64'd0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule